// File: doc/BRIEF.md
# Serial Flash Sector Protection Reader

This block is an SPI master sequencer. It fetches the per-sector protection bytes of a serial flash in a single pass. A one-cycle start request makes it pull chip-select low and clock out a fixed 32-bit read command. The command is the opcode 0x32 followed by three zero bytes. The block then clocks in one byte for each sector of the selected device size and stores each byte in a small result array indexed by sector. The serial clock is derived from the system clock by a parameterised divider and idles high (SPI mode 3). MOSI is launched on falling edges and MISO is sampled on rising edges.

The user side picks the device size with a two-bit select. It waits for the one-cycle done pulse and then reads any sector entry through a combinational read port. For each entry the port shows the raw byte, a flag that is set when the byte is 0xFF (protected) and a flag that is set when the byte is 0x00 (unprotected). The result array is cleared at each start and holds its contents until the next start.

Top module: `prot_reg_reader`

## Requirements
- R1: After reset, cs_n and sclk are high, busy and done are low, and every result entry reads 0x00.
- R2: sclk is high whenever cs_n is high, and cs_n only falls in a cycle where sclk is high.
- R3: The first 32 rising sclk edges of a transaction carry 0x32, 0x00, 0x00, 0x00 on mosi, each byte MSB first; mosi changes only together with a falling sclk edge while cs_n is low.
- R4: After the command, miso is sampled on rising sclk edges, MSB first, and returned byte k (counting from 0) is stored in result entry k.
- R5: size_sel 0 selects 4 bytes, 1 selects 8, and 2 or 3 select 16 (capped at the SECTORS parameter); a transaction has exactly 32 + 8*N rising sclk edges for N bytes.
- R6: cs_n rises only after the last rising sclk edge of the transaction, and sclk stays high from that edge until cs_n rises.
- R7: done is a one-cycle pulse in the cycle cs_n rises, and busy is low in that cycle; busy is high from the cycle after an accepted start until then.
- R8: A start while busy is ignored: the running transaction keeps its byte count and is not restarted.
- R9: Result entries are cleared to 0x00 at an accepted start, so entries at or above N read 0x00 afterwards; entries hold their values after done until the next start.
- R10: rd_prot is high exactly when the addressed entry is 0xFF, rd_unprot is high exactly when it is 0x00, and both are low for any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a read |
| size_sel | input | 2 | Device size: 0 = 4, 1 = 8, 2/3 = 16 bytes |
| rd_idx | input | $clog2(SECTORS) | Sector index of the result read port |
| rd_byte | output | 8 | Raw byte stored for rd_idx |
| rd_prot | output | 1 | Addressed byte equals 0xFF |
| rd_unprot | output | 1 | Addressed byte equals 0x00 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Flash chip-select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The bench aims at the byte-count boundary. A design that clocked one byte too many or too few would show a wrong rising-edge count, or it would leave stale or shifted bytes in the entries above N. A 16-byte read is followed by a 4-byte read, so a missing clear at start leaves old data in entries 4 to 15. A start pulse that carries a larger size is sent in the middle of a 4-byte read; a design that accepts it would restart, lengthen the transfer and fill extra entries. The slave model drives marker bytes 0xFF, 0x00 and mixed values. This exposes swapped or missing protect flags and bit-order errors in both the command capture and the data capture.

// File: rtl/prot_reg_reader.sv
module prot_reg_reader #(
  parameter int DIV     = 2,
  parameter int SECTORS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 size_sel,
  input  logic [$clog2(SECTORS)-1:0] rd_idx,
  output logic [7:0]                 rd_byte,
  output logic                       rd_prot,
  output logic                       rd_unprot,
  output logic                       busy,
  output logic                       done,
  output logic                       cs_n,
  output logic                       sclk,
  output logic                       mosi,
  input  logic                       miso
);
  localparam int IW = $clog2(SECTORS);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(32 + 8 * SECTORS + 1);
  localparam logic [7:0] OPCODE = 8'h32;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH, S_TAIL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn, last_bit, doff, nbytes;
  logic [6:0]    sh;
  logic [7:0]    mem [SECTORS];
  logic          tick, cmd_bit;

  assign busy     = (st != S_IDLE);
  assign tick     = (cnt == CW'(DIV - 1));
  assign doff     = bitn - BW'(32);
  assign cmd_bit  = (bitn < BW'(8)) ? OPCODE[3'd7 - bitn[2:0]] : 1'b0;
  assign rd_byte  = mem[rd_idx];
  assign rd_prot  = (rd_byte == 8'hFF);
  assign rd_unprot = (rd_byte == 8'h00);

  always_comb begin
    case (size_sel)
      2'd0:    nbytes = BW'(4);
      2'd1:    nbytes = BW'(8);
      default: nbytes = BW'(16);
    endcase
    if (nbytes > BW'(SECTORS)) nbytes = BW'(SECTORS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      last_bit <= '0;
      sh       <= '0;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      mosi     <= 1'b0;
      done     <= 1'b0;
      for (int i = 0; i < SECTORS; i++) mem[i] <= 8'h00;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE || tick) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          cs_n     <= 1'b0;
          bitn     <= '0;
          last_bit <= BW'(31) + (nbytes << 3);
          st       <= S_LEAD;
          for (int i = 0; i < SECTORS; i++) mem[i] <= 8'h00;
        end
        S_LEAD, S_HIGH: if (tick) begin
          sclk <= 1'b0;
          mosi <= cmd_bit;
          st   <= S_LOW;
        end
        S_LOW: if (tick) begin
          sclk <= 1'b1;
          if (bitn >= BW'(32)) begin
            sh <= {sh[5:0], miso};
            if (bitn[2:0] == 3'd7) mem[doff[IW+2:3]] <= {sh, miso};
          end
          if (bitn == last_bit) st <= S_TAIL;
          else begin
            st   <= S_HIGH;
            bitn <= bitn + 1'b1;
          end
        end
        S_TAIL: if (tick) begin
          cs_n <= 1'b1;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prot_reg_reader_chk.sv
module prot_reg_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic mosi
);
  // R2
  cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> sclk);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);
  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));
  // R6
  cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(sclk) && done));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && !busy));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !cs_n) |=> (busy || done));
endmodule

bind prot_reg_reader prot_reg_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
);

// File: tb/prot_reg_reader_bench.sv
`timescale 1ns/1ps
module prot_reg_reader_bench;
  logic       clk = 0, rst_n = 0, start = 0, miso = 0;
  logic [1:0] size_sel = 0;
  logic [3:0] rd_idx = 0;
  logic [7:0] rd_byte;
  logic       rd_prot, rd_unprot, busy, done, cs_n, sclk, mosi;

  int total = 0, bad = 0, rise_cnt = 0;
  logic [31:0] cap = 0;
  logic [7:0]  pat [16];

  always #5 clk = ~clk;

  prot_reg_reader #(.DIV(2), .SECTORS(16)) u_prot_reg_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .rd_idx(rd_idx), .rd_byte(rd_byte), .rd_prot(rd_prot), .rd_unprot(rd_unprot),
    .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // size_sel, seed
  localparam logic [9:0] VEC [4] = '{ {2'd2, 8'h5A}, {2'd0, 8'hC3}, {2'd1, 8'h17}, {2'd3, 8'hE8} };

  initial forever begin
    @(posedge sclk);
    if (!cs_n) begin
      if (rise_cnt < 32) cap = {cap[30:0], mosi};
      rise_cnt++;
    end
  end

  initial forever begin
    @(negedge sclk);
    if (!cs_n && rise_cnt >= 32) begin
      if (rise_cnt < 32 + 128) miso = pat[(rise_cnt - 32) / 8][7 - ((rise_cnt - 32) % 8)];
      else miso = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int k = 0; k < 16; k++)
      pat[k] = (k % 4 == 0) ? 8'hFF : (k % 4 == 1) ? 8'h00 : seed ^ 8'(k * 37);
  endtask

  task automatic run(input logic [1:0] sz, input int n, input bit poke);
    int w;
    rise_cnt = 0;
    cap = 0;
    size_sel = sz;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    chk(busy && !cs_n, "R7 busy after start", {busy, cs_n}, 2'b10);
    if (poke) begin
      repeat (50) @(posedge clk);
      #1 size_sel = 2'd2; start = 1;
      @(posedge clk); #1 start = 0; size_sel = sz;
    end
    w = 0;
    while (!done && w < 5000) begin
      @(posedge clk); #1 w++;
    end
    chk(w < 5000, "R7 done seen", w, 0);
    chk(cs_n && !busy, "R7 idle at done", {cs_n, busy}, 2'b10);
    @(posedge clk); #1;
    chk(!done, "R7 done one cycle", done, 0);
    chk(cap == 32'h3200_0000, "R3 command", cap, 32'h3200_0000);
    chk(rise_cnt == 32 + 8 * n, "R5 edge count", rise_cnt, 32 + 8 * n);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] e;
      e = (k < n) ? pat[k] : 8'h00;
      rd_idx = 4'(k); #1;
      chk(rd_byte == e, (k < n) ? "R4 stored byte" : "R9 cleared entry", rd_byte, e);
      chk(rd_prot == (e == 8'hFF) && rd_unprot == (e == 8'h00), "R10 flags",
          {rd_prot, rd_unprot}, {e == 8'hFF, e == 8'h00});
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(cs_n && sclk && !busy && !done, "R1 reset outputs", {cs_n, sclk, busy, done}, 4'b1100);
    chk(rd_byte == 8'h00 && rd_unprot, "R1 reset entry", rd_byte, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(cs_n && sclk, "R2 idle levels", {cs_n, sclk}, 2'b11);

    for (int v = 0; v < 4; v++) begin
      logic [1:0] sz;
      sz = VEC[v][9:8];
      fill(VEC[v][7:0]);
      run(sz, (sz == 2'd0) ? 4 : (sz == 2'd1) ? 8 : 16, 1'b0);
    end

    // R9: entries hold after done
    rd_idx = 4'd2;
    repeat (20) @(posedge clk); #1;
    chk(rd_byte == pat[2], "R9 hold after done", rd_byte, pat[2]);

    // R8: start mid-transfer ignored
    fill(8'h3C);
    run(2'd0, 4, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule